// File: doc/BRIEF.md
# Instruction Prefetch Buffer with Half-Word Realignment

This block sits between an instruction memory and a decode stage. It keeps asking memory for consecutive 32-bit words over a request/grant/response handshake, holds the returned words in a small FIFO, and carves instructions out of them. Instructions may be 16 bits (compressed) or 32 bits long and may start on any half-word boundary. A 32-bit instruction that begins in the upper half of one word is therefore stitched together from two buffered words.

The decode side sees an instruction, its address, a valid flag and a compressed flag, and accepts each instruction with a ready signal. When the pipeline redirects, it raises a flush together with a target address. The buffer then empties, answers still in flight from memory are thrown away, and fetching restarts at the word that holds the target. If the target is the upper half of that word, the lower half is skipped. Memory may stretch both grant and response over any number of cycles. New requests are made only while every outstanding answer is sure to find a free FIFO slot.

Top module: `insn_prefetch`

## Requirements
- R1: While reset is held and in the first cycle after its release, `mem_req_o` is 1, `mem_addr_o` equals the parameter `RESET_ADDR`, and `insn_valid_o` is 0.
- R2: Once `mem_req_o` is high and `mem_gnt_i` is low in a cycle without flush, `mem_req_o` stays high and `mem_addr_o` stays unchanged in the next cycle.
- R3: The FIFO holds `FIFO_DEPTH` (default 3) words. A request is raised only while buffered words plus granted but unanswered requests number fewer than `FIFO_DEPTH`. With decode stalled from reset, exactly 3 grants occur.
- R4: An instruction whose two least significant bits are not 2'b11 is compressed. `insn_cmp_o` is then 1, `insn_o` carries the 16 bits in `insn_o[15:0]` with `insn_o[31:16]` zero, and the next address is this one plus 2. Otherwise `insn_cmp_o` is 0, `insn_o` holds all 32 bits and the next address is plus 4.
- R5: A 32-bit instruction that starts at address offset 2 of a word has its low half taken from bits 31:16 of that word and its high half from bits 15:0 of the following word. It becomes valid only once both words are buffered.
- R6: On `flush_i`, bit 0 of `target_i` is ignored. The next instruction issued has address `target_i` with bit 0 cleared, and the next request goes to that address with bits 1:0 cleared. Any accept in the flush cycle is ignored.
- R7: Responses to requests granted before or in the cycle of a flush, and any response arriving in the flush cycle, never reach the decode side.
- R8: With grant always high, one-cycle response latency, decode always ready and only aligned 32-bit instructions, one instruction issues every cycle in steady state.
- R9: While `insn_valid_o` is 1 and `dec_ready_i` is 0 and there is no flush, the next cycle shows the same instruction, address and valid.
- R10: `mem_addr_o` is always word aligned, and each grant without a flush advances the next request address by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Redirect: empty the buffer and restart at target_i |
| target_i | input | 32 | Redirect address (bit 0 ignored) |
| mem_req_o | output | 1 | Fetch request to instruction memory |
| mem_addr_o | output | 32 | Word address of the request |
| mem_gnt_i | input | 1 | Memory accepted the request this cycle |
| mem_rvalid_i | input | 1 | Read data valid, one cycle per granted request |
| mem_rdata_i | input | 32 | Read data word |
| insn_o | output | 32 | Instruction (compressed ones zero extended) |
| insn_addr_o | output | 32 | Address of insn_o |
| insn_valid_o | output | 1 | insn_o is valid |
| insn_cmp_o | output | 1 | insn_o is a 16-bit instruction |
| dec_ready_i | input | 1 | Decode accepts insn_o this cycle |

## Verification
The hardest case to reach from the ports is a flush that lands while stale requests are still granted but unanswered, followed by a target at offset 2 whose 32-bit instruction straddles into a word that has not arrived yet. The stimulus gets there by delaying grants and responses at random, raising flushes often to odd and even half-word targets, and drawing instruction words from an address hash. About three quarters of the half-words then decode as compressed, so straddling 32-bit instructions occur often. A stall phase from reset fills the buffer to its limit. A phase with a memory that always answers at once checks the issue rate.

// File: rtl/pfx_pkg.sv
package pfx_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned HALF_W = 16;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [HALF_W-1:0] half_t;

  // what the realigner offers in the current cycle
  typedef struct packed {
    logic  valid;
    logic  cmp;
    logic  pop;
    word_t insn;
  } issue_t;
endpackage

// File: rtl/pfx_word_fifo.sv
module pfx_word_fifo
  import pfx_pkg::*;
#(
  parameter int unsigned DEPTH = 3,
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          push,
  input  word_t         wdata,
  input  logic          pop,
  output word_t         head,
  output half_t         next_lo,
  output logic [CW-1:0] cnt
);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  word_t         mem_q [DEPTH];
  logic [PW-1:0] rd_q, rd_d, wr_q, wr_d, rd_nxt;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ptr_en;

  function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign rd_nxt  = wrap_inc(rd_q);
  assign head    = mem_q[rd_q];
  assign next_lo = mem_q[rd_nxt][HALF_W-1:0];
  assign cnt     = cnt_q;

  always_comb begin
    rd_d  = rd_q;
    wr_d  = wr_q;
    cnt_d = cnt_q;
    if (clear) begin
      rd_d  = '0;
      wr_d  = '0;
      cnt_d = '0;
    end else begin
      if (push) wr_d = wrap_inc(wr_q);
      if (pop)  rd_d = rd_nxt;
      cnt_d = cnt_q + CW'(push) - CW'(pop);
    end
  end

  assign ptr_en = clear | push | pop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else if (ptr_en) begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
    end
  end

  // data storage carries no reset
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic slot_en;
    assign slot_en = push && !clear && (wr_q == PW'(g));
    always_ff @(posedge clk) begin
      if (slot_en) mem_q[g] <= wdata;
    end
  end
endmodule

// File: rtl/pfx_fetch_req.sv
module pfx_fetch_req
  import pfx_pkg::*;
#(
  parameter int unsigned DEPTH      = 3,
  parameter word_t       RESET_ADDR = 32'h0000_0080,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  word_t         target,
  input  logic          gnt,
  input  logic          rvalid,
  input  logic [CW-1:0] fifo_cnt,
  output logic          req,
  output word_t         addr,
  output logic          push,
  output logic [CW-1:0] outst
);
  localparam logic [CW:0] LIMIT = DEPTH[CW:0];
  localparam word_t       WMASK = ~word_t'(3);

  word_t         faddr_q, faddr_d;
  logic [CW-1:0] outst_q, outst_d, drop_q, drop_d;
  logic [CW:0]   used;
  logic          granted, faddr_en, cnt_en;

  assign used    = {1'b0, fifo_cnt} + {1'b0, outst_q};
  assign req     = used < LIMIT;
  assign granted = req & gnt;
  assign addr    = faddr_q;
  assign outst   = outst_q;
  assign push    = rvalid && (drop_q == '0) && !flush;

  always_comb begin
    faddr_d = faddr_q;
    if (flush)        faddr_d = target & WMASK;
    else if (granted) faddr_d = faddr_q + word_t'(4);
  end

  always_comb begin
    outst_d = outst_q + CW'(granted) - CW'(rvalid);
    drop_d  = drop_q;
    if (flush)                          drop_d = outst_d;
    else if (rvalid && drop_q != '0)    drop_d = drop_q - 1'b1;
  end

  assign faddr_en = flush | granted;
  assign cnt_en   = flush | granted | rvalid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        faddr_q <= RESET_ADDR & WMASK;
    else if (faddr_en) faddr_q <= faddr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outst_q <= '0;
      drop_q  <= '0;
    end else if (cnt_en) begin
      outst_q <= outst_d;
      drop_q  <= drop_d;
    end
  end
endmodule

// File: rtl/pfx_align.sv
module pfx_align
  import pfx_pkg::*;
#(
  parameter int unsigned DEPTH = 3,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          half_sel,
  input  word_t         head,
  input  half_t         next_lo,
  input  logic [CW-1:0] cnt,
  output issue_t        iss
);
  half_t first;
  logic  have1, have2, is_cmp;

  assign first  = half_sel ? head[WORD_W-1:HALF_W] : head[HALF_W-1:0];
  assign is_cmp = first[1:0] != 2'b11;
  assign have1  = cnt != '0;
  assign have2  = cnt > CW'(1);

  always_comb begin
    iss.cmp = is_cmp;
    iss.pop = half_sel | ~is_cmp;
    if (is_cmp) begin
      iss.valid = have1;
      iss.insn  = {{HALF_W{1'b0}}, first};
    end else if (half_sel) begin
      iss.valid = have2;
      iss.insn  = {next_lo, first};
    end else begin
      iss.valid = have1;
      iss.insn  = head;
    end
  end
endmodule

// File: rtl/insn_prefetch.sv
module insn_prefetch
  import pfx_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 3,
  parameter logic [31:0] RESET_ADDR = 32'h0000_0080
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        flush_i,
  input  logic [31:0] target_i,
  output logic        mem_req_o,
  output logic [31:0] mem_addr_o,
  input  logic        mem_gnt_i,
  input  logic        mem_rvalid_i,
  input  logic [31:0] mem_rdata_i,
  output logic [31:0] insn_o,
  output logic [31:0] insn_addr_o,
  output logic        insn_valid_o,
  output logic        insn_cmp_o,
  input  logic        dec_ready_i
);
  localparam int unsigned CW    = $clog2(FIFO_DEPTH + 1);
  localparam word_t       HMASK = ~word_t'(1);

  logic [CW-1:0] fifo_cnt, outst_cnt;
  logic          fifo_push, fifo_pop, fire, pc_en;
  word_t         head_w, pc_q, pc_d;
  half_t         next_lo;
  issue_t        iss;

  pfx_fetch_req #(.DEPTH(FIFO_DEPTH), .RESET_ADDR(RESET_ADDR)) u_req (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush_i),
    .target   (target_i),
    .gnt      (mem_gnt_i),
    .rvalid   (mem_rvalid_i),
    .fifo_cnt (fifo_cnt),
    .req      (mem_req_o),
    .addr     (mem_addr_o),
    .push     (fifo_push),
    .outst    (outst_cnt)
  );

  pfx_word_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (flush_i),
    .push    (fifo_push),
    .wdata   (mem_rdata_i),
    .pop     (fifo_pop),
    .head    (head_w),
    .next_lo (next_lo),
    .cnt     (fifo_cnt)
  );

  pfx_align #(.DEPTH(FIFO_DEPTH)) u_align (
    .half_sel (pc_q[1]),
    .head     (head_w),
    .next_lo  (next_lo),
    .cnt      (fifo_cnt),
    .iss      (iss)
  );

  assign fire     = iss.valid & dec_ready_i & ~flush_i;
  assign fifo_pop = fire & iss.pop;

  always_comb begin
    pc_d = pc_q;
    if (flush_i)   pc_d = target_i & HMASK;
    else if (fire) pc_d = pc_q + (iss.cmp ? word_t'(2) : word_t'(4));
  end

  assign pc_en = flush_i | fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc_q <= RESET_ADDR & HMASK;
    else if (pc_en) pc_q <= pc_d;
  end

  assign insn_o       = iss.insn;
  assign insn_addr_o  = pc_q;
  assign insn_valid_o = iss.valid;
  assign insn_cmp_o   = iss.cmp;
endmodule

// File: rtl/pfx_chk.sv
module pfx_chk #(
  parameter int unsigned DEPTH = 3,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          flush_i,
  input logic          mem_req_o,
  input logic          mem_gnt_i,
  input logic [31:0]   mem_addr_o,
  input logic          insn_valid_o,
  input logic          insn_cmp_o,
  input logic          dec_ready_i,
  input logic [31:0]   insn_o,
  input logic [31:0]   insn_addr_o,
  input logic [CW-1:0] fifo_cnt,
  input logic [CW-1:0] outst_cnt,
  input logic          fifo_push
);
  localparam logic [CW:0] LIMIT = DEPTH[CW:0];

  logic [CW:0] used;
  assign used = {1'b0, fifo_cnt} + {1'b0, outst_cnt};

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && !mem_gnt_i && !flush_i |=> mem_req_o && $stable(mem_addr_o));

  // R10
  addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> mem_addr_o[1:0] == 2'b00);

  // R3
  room_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    used <= LIMIT);

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_push |-> {1'b0, fifo_cnt} < LIMIT);

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    insn_valid_o && !dec_ready_i && !flush_i |=>
      insn_valid_o && $stable(insn_o) && $stable(insn_addr_o));

  // R6
  pc_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    insn_addr_o[0] == 1'b0);

  // R4
  cmp_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    insn_valid_o && insn_cmp_o |-> insn_o[31:16] == 16'h0 && insn_o[1:0] != 2'b11);

  // R4
  wide_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    insn_valid_o && !insn_cmp_o |-> insn_o[1:0] == 2'b11);
endmodule

bind insn_prefetch pfx_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .flush_i      (flush_i),
  .mem_req_o    (mem_req_o),
  .mem_gnt_i    (mem_gnt_i),
  .mem_addr_o   (mem_addr_o),
  .insn_valid_o (insn_valid_o),
  .insn_cmp_o   (insn_cmp_o),
  .dec_ready_i  (dec_ready_i),
  .insn_o       (insn_o),
  .insn_addr_o  (insn_addr_o),
  .fifo_cnt     (fifo_cnt),
  .outst_cnt    (outst_cnt),
  .fifo_push    (fifo_push)
);

// File: tb/insn_prefetch_bench.sv
module insn_prefetch_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] RST_PC = 32'h0000_0080;
  localparam int WD_CYCLES = 150000;

  logic        clk, rst_n, flush_i, mem_req_o, mem_gnt_i, mem_rvalid_i;
  logic        insn_valid_o, insn_cmp_o, dec_ready_i;
  logic [31:0] target_i, mem_addr_o, mem_rdata_i, insn_o, insn_addr_o;

  insn_prefetch #(.FIFO_DEPTH(3), .RESET_ADDR(RST_PC)) u_insn_prefetch (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .target_i(target_i),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_gnt_i(mem_gnt_i),
    .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i),
    .insn_o(insn_o), .insn_addr_o(insn_addr_o), .insn_valid_o(insn_valid_o),
    .insn_cmp_o(insn_cmp_o), .dec_ready_i(dec_ready_i));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_tests = 0, n_fail = 0;
  int mode = 0;                 // 0 mixed, 1 aligned 32-bit only, 2 compressed only
  int p_gnt, p_rv, p_rdy, p_flush;  // percent, percent, percent, per mille
  logic [31:0] exp_pc, exp_faddr;
  logic [31:0] q[$];
  int n_grant, n_fire;
  logic hr_pend, ho_pend, post_flush;
  logic [31:0] hr_addr, ho_insn, ho_addr;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] hw(input logic [31:0] a);
    logic [31:0] x;
    x = {a[31:1], 1'b0} * 32'h9E37_79B1;
    x = x ^ (x >> 15);
    x = x * 32'h85EB_CA6B;
    x = x ^ (x >> 13);
    if (mode == 1 && a[1] == 1'b0) x[1:0] = 2'b11;
    if (mode == 2) x[1:0] = 2'b00;
    return x[15:0];
  endfunction

  function automatic logic [31:0] mword(input logic [31:0] a);
    return {hw({a[31:2], 2'b10}), hw({a[31:2], 2'b00})};
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; flush_i = 1'b0; target_i = '0; mem_gnt_i = 1'b0;
    mem_rvalid_i = 1'b0; mem_rdata_i = '0; dec_ready_i = 1'b0;
    q.delete();
    exp_pc = RST_PC; exp_faddr = RST_PC;
    hr_pend = 1'b0; ho_pend = 1'b0; post_flush = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(mem_req_o == 1'b1, "R1 req", {31'b0, mem_req_o}, 32'd1);
    chk(mem_addr_o == RST_PC, "R1 addr", mem_addr_o, RST_PC);
    chk(insn_valid_o == 1'b0, "R1 valid", {31'b0, insn_valid_o}, 32'd0);
  endtask

  // one cycle: observe at the falling edge, then drive inputs for this cycle
  task automatic step();
    logic fl, rdy, gn, gr;
    logic [31:0] tgt, ei;
    logic [15:0] h0;
    logic ec;
    @(negedge clk);
    if (hr_pend) chk(mem_req_o && mem_addr_o == hr_addr, "R2 hold", mem_addr_o, hr_addr);
    if (ho_pend) chk(insn_valid_o && insn_o == ho_insn && insn_addr_o == ho_addr,
                     "R9 stall", insn_o, ho_insn);
    fl  = ($urandom % 1000) < p_flush;
    rdy = ($urandom % 100) < p_rdy;
    gn  = ($urandom % 100) < p_gnt;
    gr  = mem_req_o && gn;
    if (insn_valid_o && rdy && !fl) begin
      h0 = hw(exp_pc);
      ec = h0[1:0] != 2'b11;
      ei = ec ? {16'h0, h0} : {hw(exp_pc + 32'd2), h0};
      if (post_flush) chk(insn_addr_o == exp_pc, "R6 R7 first after flush", insn_addr_o, exp_pc);
      chk(insn_addr_o == exp_pc, "R4 addr", insn_addr_o, exp_pc);
      chk(insn_cmp_o == ec, "R4 cmp", {31'b0, insn_cmp_o}, {31'b0, ec});
      chk(insn_o == ei, (!ec && exp_pc[1]) ? "R5 split" : "R4 insn", insn_o, ei);
      exp_pc = exp_pc + (ec ? 32'd2 : 32'd4);
      post_flush = 1'b0;
      n_fire++;
    end
    if (gr) begin
      chk(mem_addr_o == exp_faddr, "R10 addr", mem_addr_o, exp_faddr);
      n_grant++;
    end
    if (q.size() > 0 && ($urandom % 100) < p_rv) begin
      mem_rvalid_i = 1'b1;
      mem_rdata_i  = mword(q.pop_front());
    end else begin
      mem_rvalid_i = 1'b0;
      mem_rdata_i  = $urandom;
    end
    if (gr) q.push_back(mem_addr_o);
    if (fl) begin
      tgt = 32'h0000_0100 + ($urandom % 64) * 2;
      if (($urandom % 4) == 0) tgt[0] = 1'b1;
      exp_pc = tgt & ~32'd1;
      exp_faddr = tgt & ~32'd3;
      post_flush = 1'b1;
    end else begin
      tgt = $urandom;
      if (gr) exp_faddr = exp_faddr + 32'd4;
    end
    hr_pend = mem_req_o && !gn && !fl;
    hr_addr = mem_addr_o;
    ho_pend = insn_valid_o && !rdy && !fl;
    ho_insn = insn_o;
    ho_addr = insn_addr_o;
    flush_i = fl; target_i = tgt; mem_gnt_i = gn; dec_ready_i = rdy;
  endtask

  initial begin
    #(CLK_PERIOD * WD_CYCLES);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));

    // R3: decode stalled from reset, memory fast: buffer fills to three words
    mode = 0; p_gnt = 100; p_rv = 100; p_rdy = 0; p_flush = 0;
    do_reset();
    n_grant = 0;
    repeat (20) step();
    chk(n_grant == 3, "R3 grants", n_grant, 3);
    chk(mem_req_o == 1'b0, "R3 req low", {31'b0, mem_req_o}, 32'd0);
    chk(insn_valid_o == 1'b1, "R3 valid", {31'b0, insn_valid_o}, 32'd1);

    // R8: full rate with aligned 32-bit instructions
    mode = 1; p_gnt = 100; p_rv = 100; p_rdy = 100; p_flush = 0;
    do_reset();
    repeat (20) step();
    n_fire = 0;
    repeat (40) step();
    chk(n_fire >= 38, "R8 rate", n_fire, 40);

    // compressed-only stream with redirects
    mode = 2; p_gnt = 70; p_rv = 60; p_rdy = 75; p_flush = 20;
    do_reset();
    repeat (3000) step();

    // mixed stream, heavy redirects (R6, R7) and stalls (R2, R9)
    mode = 0; p_gnt = 65; p_rv = 55; p_rdy = 70; p_flush = 40;
    do_reset();
    n_fire = 0;
    repeat (20000) step();
    chk(n_fire > 1000, "R5 progress", n_fire, 1000);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule